// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block sits beside the command bus of a four-bank double-data-rate SDRAM and watches it every clock. It turns the active-low chip select and row, column and write strobes, together with the clock enable, the two bank-address pins and the auto-precharge address bit, into a command code. It keeps a small state machine per bank (idle, open, bursting, auto-precharging) and checks each command against those states. Any command that breaks the sequencing rules raises a sticky error flag. A cause code records why the first error happened.

The checker only observes. It does not drive the memory, does not model the data path, strobe timing or masking, and has no effect on the traffic it watches. An illegal command is recorded and otherwise dropped: bank tracking continues as if it had not been issued. All outputs are registered and change on the clock edge that samples the command.

Top module: `ddr_cmd_checker`

## Requirements
- R1: The command code output gives the command sampled at the previous edge, as {cs_n,ras_n,cas_n,we_n} with clock enable high in this and the previous cycle: cs_n high or 0111 is NOP=0; 0000 is mode load=1, or extended mode load=2 when ba[0] is high; 0011 activate=3; 0101 read=4; 0100 write=5; 0010 precharge=6, or precharge-all=7 when ap is high; 0001 refresh=8; 0110 burst stop=12. With clock enable falling, 0001 is self-refresh entry=9 and anything else is power-down entry=10. With clock enable low in the previous cycle, the code is low-power exit=11 if it is now high and low-power hold=13 if it is still low.
- R2: The bank index equals ba as a 2-bit number (BA0 is ba[0]): 0 is bank A, 1 (BA0 high) is bank B, 2 (BA1 high) is bank C, 3 is bank D. Bank i's state sits at bank_state[2i+1:2i], coded 0 idle, 1 open, 2 bursting, 3 auto-precharging.
- R3: A precharge with ap high closes every open or bursting bank whatever ba holds. A single-bank precharge closes only the bank that ba selects.
- R4: A mode load or extended mode load while any bank is not idle is an error with cause 1.
- R5: In the cycle right after a legal mode or extended mode load, any command other than NOP is an error with cause 2. From the second cycle on, commands are allowed again.
- R6: Refresh or self-refresh entry while any bank is not idle is an error with cause 3.
- R7: During the burst-length/2 cycles after a write with auto precharge, any read or write to any bank is an error with cause 4.
- R8: After a read or write with auto precharge, the bank stays in state 3 for its burst plus T_RP cycles and then goes idle. An activate to a bank that is not idle is an error with cause 6. Once the locked burst is over, a read or write to another open bank is legal.
- R9: A mode load captures the burst length from mode_lo: 1 means 2, 2 means 4, 3 means 8. Other values leave the burst length unchanged, and reset selects 8. A read or write without auto precharge keeps its bank in state 2 for burst-length/2 cycles. A burst stop is always legal and returns every bank in state 2 to state 1, for every burst length.
- R10: A read or write to a bank that is neither open nor bursting is an error with cause 5.
- R11: The error flag stays set until reset, and err_cause keeps the cause of the first error. An illegal command changes no bank state, burst length or mode-load spacing.
- R12: A synchronous reset makes every bank idle, clears the error flag and cause, and sets the command code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable seen on the memory bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank-address pins, ba[0] is BA0 |
| ap | input | 1 | Auto-precharge address bit |
| mode_lo | input | 3 | Low address bits, burst-length field on a mode load |
| cmd_code | output | 4 | Decoded command of the previous cycle |
| bank_state | output | 8 | Two-bit state per bank |
| err_flag | output | 1 | Sticky sequencing-error flag |
| err_cause | output | 3 | Cause of the first error |

## Verification
Every output is due one cycle after its command: the command code, the bank states and any new error are all valid after the edge that samples the command. Later effects are measured from that edge. A burst ends burst-length/2 edges later, the write-auto-precharge lockout covers the next burst-length/2 command slots, and an auto-precharged bank reads idle T_RP edges after its burst ends. The bench drives each command half a cycle before the edge, advances its timestamp model at that edge, and compares every output at the following falling edge. Each check therefore lands in exactly the cycle the timing above predicts.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  typedef enum logic [3:0] {
    C_NOP   = 4'd0,  C_MODE  = 4'd1,  C_EMODE = 4'd2,  C_ACT   = 4'd3,
    C_RD    = 4'd4,  C_WR    = 4'd5,  C_PRE   = 4'd6,  C_PREALL= 4'd7,
    C_REF   = 4'd8,  C_SREF  = 4'd9,  C_PDN   = 4'd10, C_LPX   = 4'd11,
    C_BST   = 4'd12, C_LPH   = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0, B_OPEN = 2'd1, B_BURST = 2'd2, B_AUTOPRE = 2'd3
  } bank_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_MODE_OPEN = 3'd1, E_MODE_GAP = 3'd2, E_REF_OPEN = 3'd3,
    E_WAP_LOCK = 3'd4, E_NOT_OPEN = 3'd5, E_ACT_BUSY = 3'd6
  } cause_e;

  // Command decode from clock-enable history and the strobe nibble.
  function automatic cmd_e decode_cmd(input logic cke_prev, input logic cke,
                                      input logic [3:0] strobes,
                                      input logic ba0, input logic ap);
    if (!cke_prev) return cke ? C_LPX : C_LPH;
    if (!cke)      return (strobes == 4'b0001) ? C_SREF : C_PDN;
    if (strobes[3]) return C_NOP;
    case (strobes[2:0])
      3'b000:  return ba0 ? C_EMODE : C_MODE;
      3'b001:  return C_REF;
      3'b010:  return ap ? C_PREALL : C_PRE;
      3'b011:  return C_ACT;
      3'b100:  return C_WR;
      3'b101:  return C_RD;
      3'b110:  return C_BST;
      default: return C_NOP;
    endcase
  endfunction

  // Busy cycles of one burst (two data beats per clock); 0 marks a reserved code.
  function automatic logic [2:0] beats_for(input logic [2:0] code);
    case (code)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 ap,
  output cmd_e                 cmd,
  output logic [NUM_BANKS-1:0] tgt
);

  logic cke_prev;

  always_ff @(posedge clk) begin
    if (rst) cke_prev <= 1'b1;
    else     cke_prev <= cke;
  end

  assign cmd = decode_cmd(cke_prev, cke, {cs_n, ras_n, cas_n, we_n}, ba[0], ap);

  always_comb begin
    tgt = '0;
    case (cmd)
      C_ACT, C_RD, C_WR, C_PRE: tgt[ba] = 1'b1;
      C_PREALL:                 tgt = '1;
      default:                  tgt = '0;
    endcase
  end

  AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (cmd != C_PREALL) |-> $onehot0(tgt)); // R2

endmodule

// File: rtl/ddr_rule_check.sv
module ddr_rule_check
  import ddr_chk_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter logic [2:0]  BL_RST    = 3'd3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmd_e                 cmd,
  input  logic [NUM_BANKS-1:0] tgt,
  input  bank_e                st [NUM_BANKS],
  input  logic [NUM_BANKS-1:0] wap,
  input  logic [2:0]           mode_lo,
  output logic                 bad,
  output logic [2:0]           beats,
  output logic                 err_flag,
  output logic [2:0]           err_cause
);

  logic       gap_q;
  logic [2:0] bl_q;
  logic       all_idle, tgt_idle, tgt_open, any_wap, is_mode;
  cause_e     cause;

  always_comb begin
    all_idle = 1'b1;
    tgt_idle = 1'b1;
    tgt_open = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (st[i] != B_IDLE) all_idle = 1'b0;
      if (tgt[i]) begin
        if (st[i] != B_IDLE) tgt_idle = 1'b0;
        if (st[i] != B_OPEN && st[i] != B_BURST) tgt_open = 1'b0;
      end
    end
  end

  assign any_wap = |wap;
  assign is_mode = (cmd == C_MODE) || (cmd == C_EMODE);

  always_comb begin
    cause = E_NONE;
    if (gap_q && cmd != C_NOP) cause = E_MODE_GAP;
    else begin
      case (cmd)
        C_MODE, C_EMODE: if (!all_idle) cause = E_MODE_OPEN;
        C_REF, C_SREF:   if (!all_idle) cause = E_REF_OPEN;
        C_RD, C_WR: begin
          if (any_wap)        cause = E_WAP_LOCK;
          else if (!tgt_open) cause = E_NOT_OPEN;
        end
        C_ACT:           if (!tgt_idle) cause = E_ACT_BUSY;
        default:         cause = E_NONE;
      endcase
    end
  end

  assign bad   = (cause != E_NONE);
  assign beats = beats_for(bl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q     <= 1'b0;
      bl_q      <= BL_RST;
      err_flag  <= 1'b0;
      err_cause <= 3'd0;
    end else begin
      gap_q <= is_mode && !bad;
      if (cmd == C_MODE && !bad && beats_for(mode_lo) != 3'd0) bl_q <= mode_lo;
      if (bad && !err_flag) begin
        err_flag  <= 1'b1;
        err_cause <= cause;
      end
    end
  end

  AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    gap_q |=> !gap_q); // R5
  AST_WAP_BLOCKS_RW: assert property (@(posedge clk) disable iff (rst)
    (any_wap && (cmd == C_RD || cmd == C_WR)) |-> bad); // R7
  AST_BL_VALID: assert property (@(posedge clk) disable iff (rst)
    $countones(beats) == 1); // R9
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> $stable(err_cause)); // R11

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_chk_pkg::*;
#(
  parameter int T_RP = 3,
  localparam int CMAX = (T_RP > 4) ? T_RP : 4,
  localparam int CW   = $clog2(CMAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_act,
  input  logic       go_rw,
  input  logic       rw_ap,
  input  logic       rw_wr,
  input  logic       go_pre,
  input  logic       go_bst,
  input  logic [2:0] beats,
  output bank_e      st,
  output logic       wap
);

  logic [CW-1:0] cnt;
  logic          ap_burst;
  logic          cnt_last;

  assign cnt_last = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      ap_burst <= 1'b0;
      wap      <= 1'b0;
    end else if (go_act) begin
      st       <= B_OPEN;
      cnt      <= '0;
      ap_burst <= 1'b0;
      wap      <= 1'b0;
    end else if (go_rw) begin
      st       <= rw_ap ? B_AUTOPRE : B_BURST;
      cnt      <= CW'(beats);
      ap_burst <= rw_ap;
      wap      <= rw_ap & rw_wr;
    end else if (go_pre && (st == B_OPEN || st == B_BURST)) begin
      st  <= B_IDLE;
      cnt <= '0;
    end else if (go_bst && st == B_BURST) begin
      st  <= B_OPEN;
      cnt <= '0;
    end else begin
      case (st)
        B_BURST: begin
          if (cnt_last) begin
            st  <= B_OPEN;
            cnt <= '0;
          end else cnt <= cnt - CW'(1);
        end
        B_AUTOPRE: begin
          if (cnt_last) begin
            if (ap_burst) begin
              ap_burst <= 1'b0;
              wap      <= 1'b0;
              cnt      <= CW'(T_RP);
            end else begin
              st  <= B_IDLE;
              cnt <= '0;
            end
          end else cnt <= cnt - CW'(1);
        end
        default: cnt <= '0;
      endcase
    end
  end

  AST_BURST_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    (st == B_BURST || st == B_AUTOPRE) |-> (cnt != '0)); // R9
  AST_WAP_IN_AUTOPRE: assert property (@(posedge clk) disable iff (rst)
    wap |-> (st == B_AUTOPRE)); // R7
  AST_ACT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    go_act |-> (st == B_IDLE)); // R8
  AST_RW_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
    go_rw |-> (st == B_OPEN || st == B_BURST)); // R10

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddr_chk_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter int         T_RP      = 3,
  parameter logic [2:0] BL_RST    = 3'd3,
  localparam int BA_W = $clog2(NUM_BANKS),
  localparam int SW   = 2 * NUM_BANKS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            ap,
  input  logic [2:0]      mode_lo,
  output logic [3:0]      cmd_code,
  output logic [SW-1:0]   bank_state,
  output logic            err_flag,
  output logic [2:0]      err_cause
);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] tgt;
  bank_e                st [NUM_BANKS];
  logic [NUM_BANKS-1:0] wap;
  logic                 bad, ok;
  logic [2:0]           beats;

  ddr_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .cmd(cmd), .tgt(tgt)
  );

  ddr_rule_check #(.NUM_BANKS(NUM_BANKS), .BL_RST(BL_RST)) u_rule (
    .clk(clk), .rst(rst), .cmd(cmd), .tgt(tgt), .st(st), .wap(wap),
    .mode_lo(mode_lo), .bad(bad), .beats(beats),
    .err_flag(err_flag), .err_cause(err_cause)
  );

  assign ok = !bad;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic go_act, go_rw, go_pre, go_bst;
    assign go_act = ok && tgt[g] && (cmd == C_ACT);
    assign go_rw  = ok && tgt[g] && (cmd == C_RD || cmd == C_WR);
    assign go_pre = ok && tgt[g] && (cmd == C_PRE || cmd == C_PREALL);
    assign go_bst = ok && (cmd == C_BST);

    ddr_bank_fsm #(.T_RP(T_RP)) u_bank (
      .clk(clk), .rst(rst), .go_act(go_act), .go_rw(go_rw), .rw_ap(ap),
      .rw_wr(cmd == C_WR), .go_pre(go_pre), .go_bst(go_bst),
      .beats(beats), .st(st[g]), .wap(wap[g])
    );

    assign bank_state[2*g +: 2] = st[g];
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_code <= 4'd0;
    else     cmd_code <= cmd;
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_state == '0 && !err_flag && cmd_code == 4'd0)); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R11

endmodule

// File: tb/ddr_cmd_checker_tb.sv
module ddr_cmd_checker_tb;

  localparam int TRP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic ap = 1'b0;
  logic [2:0] mode_lo = 3'd0;
  logic [3:0] cmd_code;
  logic [7:0] bank_state;
  logic err_flag;
  logic [2:0] err_cause;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ddr_cmd_checker #(.NUM_BANKS(4), .T_RP(TRP)) u_dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .mode_lo(mode_lo),
    .cmd_code(cmd_code), .bank_state(bank_state),
    .err_flag(err_flag), .err_cause(err_cause)
  );

  // ---------------- timestamp reference model ----------------
  int n;
  int m_open[4], m_bend[4], m_apk[4];
  int m_bl, m_gap, m_errf, m_errc, m_cmd, m_ckp;

  function automatic int tb_decode(bit ckp, bit ck, bit [3:0] s, bit b0, bit apv);
    if (!ckp) return ck ? 11 : 13;
    if (!ck)  return (s == 4'b0001) ? 9 : 10;
    if (s[3]) return 0;
    case (s)
      4'b0000: return b0 ? 2 : 1;
      4'b0001: return 8;
      4'b0010: return apv ? 7 : 6;
      4'b0011: return 3;
      4'b0100: return 5;
      4'b0101: return 4;
      4'b0110: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic int tb_beats(int code);
    return 1 << (code - 1);
  endfunction

  function automatic int mstate(int i, int t);
    if (m_apk[i] != 0) return (t < m_bend[i] + TRP) ? 3 : 0;
    if (m_open[i] == 0) return 0;
    return (t < m_bend[i]) ? 2 : 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_bend[i] = 0; m_apk[i] = 0;
    end
    m_bl = 3; m_gap = -1; m_errf = 0; m_errc = 0; m_cmd = 0; m_ckp = 1;
  endtask

  task automatic model_step();
    int e, code, cause;
    int sb[4];
    bit lock, allidle;
    bit [3:0] tg;
    e = n + 1;
    if (rst) begin
      model_reset();
      n = e;
      return;
    end
    code = tb_decode(m_ckp[0], cke, {cs_n, ras_n, cas_n, we_n}, ba[0], ap);
    m_ckp = cke;
    lock = 0; allidle = 1;
    for (int i = 0; i < 4; i++) begin
      sb[i] = mstate(i, e - 1);
      if (sb[i] != 0) allidle = 0;
      if (m_apk[i] == 2 && e <= m_bend[i]) lock = 1;
    end
    tg = 4'h0;
    if (code >= 3 && code <= 6) tg[ba] = 1'b1;
    if (code == 7) tg = 4'hf;
    cause = 0;
    if (m_gap == e && code != 0) cause = 2;
    else if ((code == 1 || code == 2) && !allidle) cause = 1;
    else if ((code == 8 || code == 9) && !allidle) cause = 3;
    else if ((code == 4 || code == 5) && lock) cause = 4;
    else if ((code == 4 || code == 5) && !(sb[ba] == 1 || sb[ba] == 2)) cause = 5;
    else if (code == 3 && sb[ba] != 0) cause = 6;
    m_gap = -1;
    if (cause == 0) begin
      if (code == 1 || code == 2) m_gap = e + 1;
      if (code == 1 && mode_lo >= 1 && mode_lo <= 3) m_bl = mode_lo;
      if (code == 3) begin
        m_open[ba] = 1; m_apk[ba] = 0; m_bend[ba] = 0;
      end
      if (code == 4 || code == 5) begin
        m_open[ba] = 1;
        m_apk[ba]  = ap ? ((code == 5) ? 2 : 1) : 0;
        m_bend[ba] = e + tb_beats(m_bl);
      end
      for (int i = 0; i < 4; i++) begin
        if ((code == 6 || code == 7) && tg[i] && (sb[i] == 1 || sb[i] == 2)) begin
          m_open[i] = 0; m_apk[i] = 0;
        end
        if (code == 12 && m_apk[i] == 0 && sb[i] == 2) m_bend[i] = e;
      end
    end
    if (cause != 0 && m_errf == 0) begin
      m_errf = 1; m_errc = cause;
    end
    m_cmd = code;
    n = e;
  endtask

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, n);
    end
  endtask

  task automatic compare_all();
    int exp_bs;
    exp_bs = 0;
    for (int i = 0; i < 4; i++) exp_bs |= mstate(i, n) << (2 * i);
    chk("R1 cmd_code", cmd_code, m_cmd);
    chk("R2 bank_state", bank_state, exp_bs);
    chk("R11 err_flag", err_flag, m_errf);
    chk("R11 err_cause", err_cause, m_errc);
  endtask

  task automatic tick(input bit [3:0] s, input bit ck, input bit [1:0] b,
                      input bit apv, input bit [2:0] a);
    {cs_n, ras_n, cas_n, we_n} = s;
    cke = ck; ba = b; ap = apv; mode_lo = a;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic nop();                       tick(4'b0111, 1, 0, 0, 0); endtask
  task automatic act(input bit [1:0] b);       tick(4'b0011, 1, b, 0, 0); endtask
  task automatic rd(input bit [1:0] b, input bit apv); tick(4'b0101, 1, b, apv, 0); endtask
  task automatic wr(input bit [1:0] b, input bit apv); tick(4'b0100, 1, b, apv, 0); endtask
  task automatic pre(input bit [1:0] b);       tick(4'b0010, 1, b, 0, 0); endtask
  task automatic preall(input bit [1:0] b);    tick(4'b0010, 1, b, 1, 0); endtask
  task automatic bst();                        tick(4'b0110, 1, 0, 0, 0); endtask
  task automatic mrs(input bit [2:0] a);       tick(4'b0000, 1, 0, 0, a); endtask
  task automatic emrs();                       tick(4'b0000, 1, 1, 0, 0); endtask
  task automatic refr();                       tick(4'b0001, 1, 0, 0, 0); endtask

  task automatic do_reset();
    rst = 1'b1;
    nop();
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    n = 0;
    model_reset();
    @(negedge clk);
    do_reset();
    chk("R12 reset banks idle", bank_state, 0);
    chk("R12 reset error clear", err_flag, 0);
    chk("R12 reset cmd code", cmd_code, 0);

    // burst length 2, all four banks, bank index mapping
    mrs(3'd1); nop();
    act(0); act(1); act(2); act(3);
    chk("R2 four banks open", bank_state, 8'h55);
    rd(1, 0);
    chk("R9 BL2 bank B bursting", bank_state[3:2], 2);
    chk("R1 read code", cmd_code, 4);
    nop();
    chk("R9 BL2 burst over", bank_state[3:2], 1);
    pre(2);
    chk("R3 single precharge bank C", bank_state, 8'h45);
    preall(2'd2);
    chk("R3 precharge all ignores ba", bank_state, 0);
    chk("R3 no error", err_flag, 0);

    // burst length 8, burst stop, reserved code
    mrs(3'd3); nop(); act(2); wr(2, 0); nop();
    chk("R9 BL8 still bursting", bank_state[5:4], 2);
    bst();
    chk("R9 burst stop at BL8", bank_state[5:4], 1);
    pre(2); mrs(3'd5); nop(); act(0); rd(0, 0); nop(); nop(); nop();
    chk("R9 reserved code keeps BL8", bank_state[1:0], 2);
    nop();
    chk("R9 BL8 burst of four cycles done", bank_state[1:0], 1);
    chk("R9 no error", err_flag, 0);

    // write with auto precharge lockout
    do_reset();
    act(0); act(1); wr(0, 1); rd(1, 0);
    chk("R7 lockout error", err_flag, 1);
    chk("R7 lockout cause", err_cause, 4);

    // after lockout: other bank allowed, same bank only after T_RP
    do_reset();
    act(0); act(1); wr(0, 1);
    for (int i = 0; i < 4; i++) nop();
    rd(1, 0);
    chk("R8 other bank read after burst", err_flag, 0);
    chk("R8 bank A auto-precharging", bank_state[1:0], 3);
    for (int i = 0; i < TRP - 1; i++) nop();
    chk("R8 bank A idle after T_RP", bank_state[1:0], 0);
    act(0);
    chk("R8 late activate legal", err_flag, 0);
    do_reset();
    act(0); wr(0, 1);
    for (int i = 0; i < 3 + TRP; i++) nop();
    act(0);
    chk("R8 early activate error", err_cause, 6);

    // mode load with open bank
    do_reset();
    act(3); mrs(3'd2);
    chk("R4 mode load open bank", err_cause, 1);
    // refresh / self refresh
    do_reset();
    act(1); refr();
    chk("R6 refresh open bank", err_cause, 3);
    do_reset();
    act(1); tick(4'b0001, 0, 0, 0, 0);
    chk("R6 self refresh open bank", err_cause, 3);
    do_reset();
    tick(4'b0001, 0, 0, 0, 0);
    chk("R1 self refresh entry code", cmd_code, 9);
    tick(4'b0111, 0, 0, 0, 0);
    chk("R1 low power hold code", cmd_code, 13);
    tick(4'b0111, 1, 0, 0, 0);
    chk("R1 low power exit code", cmd_code, 11);
    chk("R6 idle self refresh legal", err_flag, 0);

    // mode load spacing
    do_reset();
    emrs();
    chk("R1 extended mode code", cmd_code, 2);
    act(0);
    chk("R5 command right after mode load", err_cause, 2);
    chk("R11 illegal activate no effect", bank_state, 0);
    do_reset();
    mrs(3'd2); nop(); act(0);
    chk("R5 command two cycles later", err_flag, 0);

    // not open, sticky first cause
    do_reset();
    act(0); rd(1, 0);
    chk("R10 read to idle bank", err_cause, 5);
    act(0);
    chk("R11 first cause kept", err_cause, 5);
    chk("R11 flag stays", err_flag, 1);
    wr(2, 0);
    chk("R11 illegal write no effect", bank_state, 8'h01);

    // random traffic against the model
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      int r;
      bit [1:0] b;
      r = $urandom_range(0, 15);
      b = 2'($urandom_range(0, 3));
      if (m_errf != 0 && $urandom_range(0, 3) == 0) do_reset();
      else if (m_ckp == 0) tick(4'b0111, ($urandom_range(0, 2) == 0), 0, 0, 0);
      else case (r)
        0:       tick({1'b1, 3'($urandom_range(0, 7))}, 1, b, 0, 0);
        1, 2:    nop();
        3, 4, 5: act(b);
        6:       rd(b, 1'($urandom_range(0, 1)));
        7:       wr(b, 1'($urandom_range(0, 1)));
        8:       pre(b);
        9:       preall(b);
        10:      bst();
        11:      mrs(3'($urandom_range(0, 7)));
        12:      emrs();
        13:      refr();
        14:      tick(($urandom_range(0, 1) == 0) ? 4'b0001 : 4'b0111, 0, 0, 0, 0);
        default: nop();
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule